// File: doc/BRIEF.md
# Integer Arithmetic Unit with Status Flags

This block is a purely combinational integer arithmetic stage. It takes two operands, a three-bit operation code and the carry flag currently held by the surrounding machine. It returns the result together with five status flags: zero, sign, carry, overflow and parity. A five-bit write-enable mask tells the flag register which of those flags the operation is allowed to update.

Seven operations are provided: plain add and subtract, add and subtract with the incoming carry, increment, decrement and negate. Arithmetic wider than the datapath is done over several passes. The low word uses a plain add or subtract. Each higher word then uses the carry-consuming form, and the carry flag from one pass is fed back as the carry input of the next. Increment and decrement do not disturb the carry, so a loop counter can run in the middle of such a chain.

Top module: `arithFlagUnit`

## Requirements
- R1: `zeroFlag` is 1 exactly when the result is all zeros, for every valid operation.
- R2: `signFlag` equals the most significant bit of the result.
- R3: `parityFlag` is 1 when the low 8 bits of the result hold an even number of ones.
- R4: Opcode 0 (add) gives `opndA+opndB` with `carryFlag` set on unsigned wrap. Opcode 1 (subtract) gives `opndA-opndB` with `carryFlag` set when `opndA` is below `opndB` as unsigned values (a borrow). For example, 0xFFFFFFFF plus 1 gives 0 with carry set.
- R5: `ovflFlag` is set on signed overflow. For add-type operations this is when both operands share a sign and the result sign differs. For subtract-type operations it is when the operand signs differ and the result sign differs from the minuend.
- R6: Opcode 2 adds `carryIn` to the operand sum. Opcode 3 subtracts `opndB` plus `carryIn`, and sets carry when the minuend is below that total. A low-word add or subtract followed by opcode 2 or 3 on the higher words, with the carry fed back, yields the exact multi-word sum or difference.
- R7: Opcode 4 (increment) and opcode 5 (decrement) compute `opndA±1` and ignore `opndB`. They clear bit 2 of `flagWrEn`, and `carryFlag` repeats `carryIn`.
- R8: Opcode 6 (negate) returns the two's complement of `opndA` and ignores `opndB`. Carry is set exactly when `opndA` is nonzero. Negating 0x80000000 returns 0x80000000 and sets overflow.
- R9: Opcode 7 is reserved. It returns result 0, clears `flagWrEn`, outputs zero for every flag except `carryFlag`, and makes `carryFlag` repeat `carryIn`.
- R10: `flagWrEn` bits are ordered 0 zero, 1 sign, 2 carry, 3 overflow, 4 parity. All five bits are set for opcodes 0–3 and 6, and every bit except bit 2 is set for opcodes 4 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opndA | input | 32 | First operand (minuend, or the operand of increment/decrement/negate) |
| opndB | input | 32 | Second operand |
| opCode | input | 3 | Operation select, encoded as in R4–R9 |
| carryIn | input | 1 | Current carry flag |
| result | output | 32 | Arithmetic result |
| zeroFlag | output | 1 | Zero flag |
| signFlag | output | 1 | Sign flag |
| carryFlag | output | 1 | Carry / borrow flag |
| ovflFlag | output | 1 | Signed overflow flag |
| parityFlag | output | 1 | Even parity of the low result byte |
| flagWrEn | output | 5 | Per-flag write enables |

## Verification
The hardest cases to reach are the carry-consuming subtract at its exact borrow boundary and a genuine multi-word chain. In the boundary case, the minuend equals the subtrahend and the incoming carry tips the result into a borrow. In the chain, the carry that enters each pass must be the one the unit itself produced on the previous pass. The bench builds such chains by feeding the observed `carryFlag` back into `carryIn` for the next word. It sometimes runs an increment in the middle of a chain and checks the reassembled 64-bit value. Directed vectors hit the boundary operands 0, 1, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF with both carry values. Random vectors are biased toward those same values.

// File: rtl/arithFlagPkg.sv
package arithFlagPkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_ADC  = 3'd2,
    OP_SBB  = 3'd3,
    OP_INC  = 3'd4,
    OP_DEC  = 3'd5,
    OP_NEG  = 3'd6,
    OP_NONE = 3'd7
  } aluOpE;

  // strobes from control to datapath
  typedef struct packed {
    logic valid;      // a defined operation
    logic invertB;    // subtract: add the inverted right operand
    logic useCarry;   // fold the incoming carry in
    logic zeroA;      // negate: left operand is zero, right operand is A
    logic oneB;       // increment/decrement: right operand is constant one
    logic keepCarry;  // carry flag passes through
  } aluStrobeS;

  localparam int FLAG_COUNT = 5;
  localparam int FLG_ZF = 0;
  localparam int FLG_SF = 1;
  localparam int FLG_CF = 2;
  localparam int FLG_OF = 3;
  localparam int FLG_PF = 4;
endpackage

// File: rtl/arithCtrl.sv
module arithCtrl
  import arithFlagPkg::*;
(
  input  logic [2:0]            opCode,
  output aluStrobeS             strb,
  output logic [FLAG_COUNT-1:0] wrMask
);
  always_comb begin
    strb = '0;
    unique case (aluOpE'(opCode))
      OP_ADD: strb.valid = 1'b1;
      OP_SUB: begin strb.valid = 1'b1; strb.invertB = 1'b1; end
      OP_ADC: begin strb.valid = 1'b1; strb.useCarry = 1'b1; end
      OP_SBB: begin strb.valid = 1'b1; strb.invertB = 1'b1; strb.useCarry = 1'b1; end
      OP_INC: begin strb.valid = 1'b1; strb.oneB = 1'b1; strb.keepCarry = 1'b1; end
      OP_DEC: begin
        strb.valid = 1'b1; strb.oneB = 1'b1; strb.invertB = 1'b1; strb.keepCarry = 1'b1;
      end
      OP_NEG: begin strb.valid = 1'b1; strb.zeroA = 1'b1; strb.invertB = 1'b1; end
      default: strb.keepCarry = 1'b1;
    endcase
  end

  always_comb begin
    wrMask = '0;
    if (strb.valid) begin
      wrMask = '1;
      if (strb.keepCarry) wrMask[FLG_CF] = 1'b0;
    end
  end

  always_comb begin
    if (!$isunknown(opCode)) begin
      // R8
      operand_sel_chk: assert ($onehot0({strb.zeroA, strb.oneB}))
        else $error("negate and constant-one selected together");
    end
  end
endmodule

// File: rtl/arithDatapath.sv
module arithDatapath
  import arithFlagPkg::*;
#(
  parameter int WIDTH       = 32,
  parameter int PARITY_BITS = 8
) (
  input  logic [WIDTH-1:0] opndA,
  input  logic [WIDTH-1:0] opndB,
  input  logic             carryIn,
  input  aluStrobeS        strb,
  output logic [WIDTH-1:0] result,
  output logic             zeroFlag,
  output logic             signFlag,
  output logic             carryFlag,
  output logic             ovflFlag,
  output logic             parityFlag
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] leftOp, rightSel, rightOp;
  logic             carryRaw, carryFold;
  logic [WIDTH:0]   sumWide;

  always_comb begin
    leftOp    = strb.zeroA ? '0 : opndA;
    rightSel  = strb.oneB ? WIDTH'(1) : (strb.zeroA ? opndA : opndB);
    rightOp   = strb.invertB ? ~rightSel : rightSel;
    carryRaw  = strb.useCarry & carryIn;
    carryFold = strb.invertB ? ~carryRaw : carryRaw;
    sumWide   = {1'b0, leftOp} + {1'b0, rightOp} + {{WIDTH{1'b0}}, carryFold};
  end

  always_comb begin
    result     = strb.valid ? sumWide[MSB:0] : '0;
    zeroFlag   = strb.valid & (result == '0);
    signFlag   = result[MSB];
    parityFlag = strb.valid & ~^result[PARITY_BITS-1:0];
    ovflFlag   = strb.valid & (leftOp[MSB] == rightOp[MSB]) & (sumWide[MSB] != leftOp[MSB]);
    if (strb.keepCarry)    carryFlag = carryIn;
    else if (strb.invertB) carryFlag = ~sumWide[WIDTH];
    else                   carryFlag = sumWide[WIDTH];
  end

  always_comb begin
    if (!$isunknown({opndA, strb})) begin
      // R8
      neg_carry_chk: assert (!(strb.valid && strb.zeroA) || (carryFlag == (opndA != '0)))
        else $error("negate carry does not track a nonzero operand");
      // R5
      add_ovfl_sign_chk: assert (!(ovflFlag && !strb.invertB) || (opndA[MSB] == rightSel[MSB]))
        else $error("add overflow with operands of differing sign");
    end
  end
endmodule

// File: rtl/arithFlagUnit.sv
module arithFlagUnit
  import arithFlagPkg::*;
#(
  parameter int WIDTH       = 32,
  parameter int PARITY_BITS = 8
) (
  input  logic [WIDTH-1:0]      opndA,
  input  logic [WIDTH-1:0]      opndB,
  input  logic [2:0]            opCode,
  input  logic                  carryIn,
  output logic [WIDTH-1:0]      result,
  output logic                  zeroFlag,
  output logic                  signFlag,
  output logic                  carryFlag,
  output logic                  ovflFlag,
  output logic                  parityFlag,
  output logic [FLAG_COUNT-1:0] flagWrEn
);
  aluStrobeS strb;

  arithCtrl u_ctrl (
    .opCode (opCode),
    .strb   (strb),
    .wrMask (flagWrEn)
  );

  arithDatapath #(.WIDTH(WIDTH), .PARITY_BITS(PARITY_BITS)) u_dp (
    .opndA      (opndA),
    .opndB      (opndB),
    .carryIn    (carryIn),
    .strb       (strb),
    .result     (result),
    .zeroFlag   (zeroFlag),
    .signFlag   (signFlag),
    .carryFlag  (carryFlag),
    .ovflFlag   (ovflFlag),
    .parityFlag (parityFlag)
  );

  always_comb begin
    if (!$isunknown({opCode, carryIn, opndA, opndB})) begin
      // R7
      keep_cf_chk: assert (flagWrEn[FLG_CF] || (carryFlag == carryIn))
        else $error("carry changed while its write enable is low");
      // R1
      zero_parity_chk: assert (!(zeroFlag && flagWrEn[FLG_ZF]) || (parityFlag && !signFlag))
        else $error("zero result with odd parity or negative sign");
    end
  end
endmodule

// File: tb/test_arithFlagUnit.sv
module test_arithFlagUnit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] opndA = '0, opndB = '0;
  logic [2:0]  opCode = 3'd0;
  logic        carryIn = 1'b0;
  logic [31:0] result;
  logic        zeroFlag, signFlag, carryFlag, ovflFlag, parityFlag;
  logic [4:0]  flagWrEn;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  always #5 clk = ~clk;

  arithFlagUnit i_arithFlagUnit (
    .opndA(opndA), .opndB(opndB), .opCode(opCode), .carryIn(carryIn),
    .result(result), .zeroFlag(zeroFlag), .signFlag(signFlag), .carryFlag(carryFlag),
    .ovflFlag(ovflFlag), .parityFlag(parityFlag), .flagWrEn(flagWrEn)
  );

  function automatic string reqOf(input int op);
    case (op)
      0, 1: return "R4";
      2, 3: return "R6";
      4, 5: return "R7";
      6: return "R8";
      default: return "R9";
    endcase
  endfunction

  // behavioural reference: wide integer arithmetic, range tests for overflow
  function automatic void model(input int op, input logic [31:0] a, b, input logic c,
                                output logic [31:0] r, output logic [4:0] fl, output logic [4:0] we);
    longint ua = longint'({32'b0, a});
    longint ub = longint'({32'b0, b});
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    longint cc = c ? 1 : 0;
    longint t = 0, st = 0;
    logic cf = 1'b0;
    we = 5'b11111;
    case (op)
      0: begin t = ua + ub;      st = sa + sb;      cf = t > 64'hFFFF_FFFF; end
      1: begin t = ua - ub;      st = sa - sb;      cf = ua < ub; end
      2: begin t = ua + ub + cc; st = sa + sb + cc; cf = t > 64'hFFFF_FFFF; end
      3: begin t = ua - ub - cc; st = sa - sb - cc; cf = ua < ub + cc; end
      4: begin t = ua + 1;       st = sa + 1;       cf = c; we = 5'b11011; end
      5: begin t = ua - 1;       st = sa - 1;       cf = c; we = 5'b11011; end
      6: begin t = -ua;          st = -sa;          cf = (a != 0); end
      default: begin
        r = '0; fl = {4'b0000, 1'b0}; fl[2] = c; we = '0;
        return;
      end
    endcase
    r = 32'(t);
    fl[0] = (r == 0);
    fl[1] = r[31];
    fl[2] = cf;
    fl[3] = (st > 64'sd2147483647) || (st < -64'sd2147483648);
    fl[4] = ($countones(r[7:0]) % 2 == 0);
  endfunction

  task automatic applyVec(input int op, input logic [31:0] a, b, input logic c,
                          output logic [31:0] gotR, output logic gotC);
    logic [31:0] eR;
    logic [4:0]  eF, eW, gF;
    bit bad = 0;
    string rq = reqOf(op);
    @(posedge clk); #1;
    opCode = 3'(op); opndA = a; opndB = b; carryIn = c;
    @(negedge clk);
    model(op, a, b, c, eR, eF, eW);
    gF = {parityFlag, ovflFlag, carryFlag, signFlag, zeroFlag};
    vectors++;
    if (result !== eR) begin bad = 1;
      $display("FAIL %s result op=%0d a=%h b=%h c=%b: got %h exp %h", rq, op, a, b, c, result, eR); end
    if (gF[0] !== eF[0]) begin bad = 1;
      $display("FAIL R1 zero op=%0d a=%h b=%h: got %b exp %b", op, a, b, gF[0], eF[0]); end
    if (gF[1] !== eF[1]) begin bad = 1;
      $display("FAIL R2 sign op=%0d a=%h b=%h: got %b exp %b", op, a, b, gF[1], eF[1]); end
    if (gF[2] !== eF[2]) begin bad = 1;
      $display("FAIL %s carry op=%0d a=%h b=%h c=%b: got %b exp %b", rq, op, a, b, c, gF[2], eF[2]); end
    if (gF[3] !== eF[3]) begin bad = 1;
      $display("FAIL R5 ovfl op=%0d a=%h b=%h c=%b: got %b exp %b", op, a, b, c, gF[3], eF[3]); end
    if (gF[4] !== eF[4]) begin bad = 1;
      $display("FAIL R3 parity op=%0d a=%h b=%h: got %b exp %b", op, a, b, gF[4], eF[4]); end
    if (flagWrEn !== eW) begin bad = 1;
      $display("FAIL %s wren op=%0d: got %b exp %b", (op == 7) ? "R9" : "R10", op, flagWrEn, eW); end
    if (bad) miscompares++;
    gotR = result; gotC = carryFlag;
  endtask

  function automatic logic [31:0] edgeVal(input int sel);
    case (sel % 8)
      0: return 32'h0;
      1: return 32'h1;
      2: return 32'h7FFF_FFFF;
      3: return 32'h8000_0000;
      4: return 32'hFFFF_FFFF;
      default: return $urandom();
    endcase
  endfunction

  // R6: multi-word chain with carry fed back from the unit itself
  task automatic chain64(input bit sub, input bit midInc, input logic [63:0] x, y);
    logic [31:0] lo, hi, dummy;
    logic cLo, cHi, cMid;
    logic [63:0] exp64;
    applyVec(sub ? 1 : 0, x[31:0], y[31:0], 1'b0, lo, cLo);
    cMid = cLo;
    if (midInc) applyVec(4, $urandom(), $urandom(), cLo, dummy, cMid);
    applyVec(sub ? 3 : 2, x[63:32], y[63:32], cMid, hi, cHi);
    exp64 = sub ? x - y : x + y;
    vectors++;
    if ({hi, lo} !== exp64) begin
      miscompares++;
      $display("FAIL R6 chain sub=%0d: got %h exp %h", sub, {hi, lo}, exp64);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic c;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset state: inputs idle at add 0+0 (R1, R3)
    applyVec(0, 32'h0, 32'h0, 1'b0, r, c);
    applyVec(0, 32'hFFFF_FFFF, 32'h1, 1'b0, r, c);   // R4 wrap
    applyVec(0, 32'h7FFF_FFFF, 32'h1, 1'b0, r, c);   // R5
    applyVec(1, 32'h0, 32'h1, 1'b0, r, c);           // R4 borrow
    applyVec(1, 32'h8000_0000, 32'h1, 1'b0, r, c);   // R5
    applyVec(2, 32'hFFFF_FFFF, 32'h0, 1'b1, r, c);   // R6
    applyVec(3, 32'h5, 32'h5, 1'b1, r, c);           // R6 borrow boundary
    applyVec(3, 32'h5, 32'h5, 1'b0, r, c);           // R6
    applyVec(4, 32'hFFFF_FFFF, 32'h1234, 1'b0, r, c);// R7
    applyVec(4, 32'h7FFF_FFFF, 32'h0, 1'b1, r, c);   // R7
    applyVec(5, 32'h0, 32'hFFFF, 1'b1, r, c);        // R7
    applyVec(6, 32'h0, 32'hABCD, 1'b1, r, c);        // R8
    applyVec(6, 32'h8000_0000, 32'h0, 1'b0, r, c);   // R8
    applyVec(6, 32'h5, 32'h0, 1'b0, r, c);           // R8
    applyVec(7, 32'h1234, 32'h5678, 1'b1, r, c);     // R9
    applyVec(7, 32'h1234, 32'h5678, 1'b0, r, c);     // R9
    chain64(0, 0, 64'h0000_0001_FFFF_FFFF, 64'h0000_0000_0000_0002);
    chain64(1, 0, 64'h0000_0001_0000_0000, 64'h0000_0000_0000_0001);
    chain64(0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001);
    for (int i = 0; i < 200; i++)
      chain64(i % 2, (i % 5) == 0, {$urandom(), $urandom()}, {$urandom(), $urandom()});
    for (int i = 0; i < 3000; i++)
      applyVec(int'($urandom_range(0, 7)), edgeVal(int'($urandom())), edgeVal(int'($urandom())),
               1'($urandom()), r, c);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule